// File: doc/BRIEF.md
# Trace Address Comparator Register Bank

This block holds the 64-bit address values used by the address comparators of a trace unit, up to sixteen registers arranged as comparator pairs. Software reaches it through a system-register access port. Each access presents its five encoding fields, a read/write flag, write data, the current exception level and the trap-control bits. The block works out which register is meant and whether that register exists. It then decides whether the access completes, is undefined, or traps to a higher exception level. A trap carries a target level and syndrome class 0x18.

An access that completes reads or writes the selected register. A write is allowed only while the trace unit is Idle. A write outside Idle is dropped and sets a sticky error flag. Before a write is stored, the bits above the virtual address size are made canonical. In parallel, each present register compares its stored value with a trace address. A 32-bit address is zero-extended to 64 bits before that compare.

The response is registered and appears one cycle after the access is presented. The compare result is combinational.

Top module: `trace_acmp_bank`

## Requirements
- R1: An access is addressed to this bank only when op0=2'b10, op1=3'b001, CRn=4'b0010, CRm[0]=0 and op2[2:1]=2'b00. The register index is {op2[0], CRm[3:1]}. Any other encoding answers with kind 3 (not addressed) and zero read data, and changes no register.
- R2: Register n is present only when n < 2*NUM_PAIRS. An addressed access from EL1 to EL3 that targets an absent register answers kind 1 (undefined).
- R3: Any addressed access from EL0 answers kind 1 (undefined). This check comes before the presence check.
- R4: An access from EL1 is checked in this order, and the first condition that holds decides the result:
  - trap to EL1 when el1_trap is set;
  - trap to EL2 when EL2 is enabled, runs 64-bit and el2_trap is set;
  - trap to EL3 when EL3 exists, runs 64-bit and el3_trap is set;
  - otherwise the access completes.
- R5: An access from EL2 traps to EL2 when el2_trap is set, whether or not EL2 is enabled. Otherwise it traps to EL3 under the EL3 condition of R4, and otherwise it completes.
- R6: An access from EL3 traps to EL3 only when el3_trap is set. The EL1 and EL2 bits have no effect on it.
- R7: Every trap answers kind 2 with syndrome class 6'h18. Every answer other than kind 0 carries zero read data and a class of zero except for traps. A trapped or undefined write changes no register.
- R8: Response kinds are 0 = done, 1 = undefined, 2 = trap, 3 = not addressed. The response is valid on the cycle after the access. A completed read returns the stored value, and a completed write returns zero read data.
- R9: When write bits [63:VA_BITS] are all zeros or all ones, they are stored and read back exactly as written.
- R10: When write bits [63:VA_BITS] are mixed, they are stored as copies of bit VA_BITS-1.
- R11: A completed write while unit_idle is low stores nothing and sets wr_busy_err. The flag stays set until reset.
- R12: cmp_hit[n] is set when register n is present and equals cmp_addr. When cmp_narrow is high, cmp_addr is first cut to its low 32 bits and zero-extended. Bits for absent registers are always zero.
- R13: Reset clears every register to zero, clears wr_busy_err and drops rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_wdata | input | 64 | Write data |
| cur_el | input | 2 | Exception level of the access |
| el1_trap | input | 1 | EL1 trace-access trap control |
| el2_trap | input | 1 | EL2 trace-access trap control |
| el3_trap | input | 1 | EL3 trace-access trap control |
| el2_enabled | input | 1 | EL2 is enabled |
| el2_is64 | input | 1 | EL2 runs 64-bit |
| el3_present | input | 1 | EL3 is implemented |
| el3_is64 | input | 1 | EL3 runs 64-bit |
| unit_idle | input | 1 | Trace unit is in its Idle state |
| rsp_valid | output | 1 | Response valid |
| rsp_kind | output | 2 | 0 done, 1 undefined, 2 trap, 3 not addressed |
| rsp_tgt_el | output | 2 | Trap target level (zero unless trap) |
| rsp_class | output | 6 | Syndrome class (6'h18 on trap) |
| rsp_rdata | output | 64 | Read data |
| wr_busy_err | output | 1 | Sticky: write attempted outside Idle |
| cmp_addr | input | 64 | Trace address to compare |
| cmp_narrow | input | 1 | Address is 32-bit; zero-extend it |
| cmp_hit | output | 16 | Per-register equality result |

## Verification
The bench builds the bank with NUM_PAIRS=3, so only registers 0 to 5 exist. This puts the absent indices 6 to 15 within reach, which exercises the presence rule and the constant-zero hit bits. VA_BITS stays at 48, so bits 63:48 are the canonical field. Patterns that are all zeros, all ones, and mixed with both values of bit 47 all land on real storage. The trap chain is driven through every priority step from each exception level. The compare is checked with a 32-bit address whose upper half is set, to prove the zero-extension.

// File: rtl/trace_acmp_pkg.sv
package trace_acmp_pkg;
   localparam int          MAX_REGS   = 16;
   localparam int          IDX_W      = 4;
   localparam logic [5:0]  TRAP_CLASS = 6'h18;

   typedef enum logic [1:0] {
      RSP_DONE  = 2'd0,
      RSP_UNDEF = 2'd1,
      RSP_TRAP  = 2'd2,
      RSP_NOHIT = 2'd3
   } rsp_kind_e;
endpackage

// File: rtl/tacmp_decode.sv
module tacmp_decode
   import trace_acmp_pkg::*;
#(
   parameter int NUM_PAIRS = 8
) (
   input  logic [1:0]       op0,
   input  logic [2:0]       op1,
   input  logic [3:0]       crn,
   input  logic [3:0]       crm,
   input  logic [2:0]       op2,
   output logic             addr_hit,
   output logic [IDX_W-1:0] reg_idx,
   output logic             present
);
   localparam int NPRES = 2 * NUM_PAIRS;

   assign addr_hit = (op0 == 2'b10) && (op1 == 3'b001) && (crn == 4'b0010)
                     && !crm[0] && (op2[2:1] == 2'b00);
   assign reg_idx  = {op2[0], crm[3:1]};
   assign present  = int'(reg_idx) < NPRES;
endmodule

// File: rtl/tacmp_trap.sv
module tacmp_trap
   import trace_acmp_pkg::*;
(
   input  logic      [1:0] el,
   input  logic            el1_trap,
   input  logic            el2_trap,
   input  logic            el3_trap,
   input  logic            el2_enabled,
   input  logic            el2_is64,
   input  logic            el3_present,
   input  logic            el3_is64,
   output rsp_kind_e       kind,
   output logic      [1:0] tgt
);
   logic el2_gate, el3_gate;

   assign el2_gate = el2_enabled && el2_is64 && el2_trap;
   assign el3_gate = el3_present && el3_is64 && el3_trap;

   always_comb begin
      kind = RSP_DONE;
      tgt  = 2'd0;
      unique case (el)
         2'd0: kind = RSP_UNDEF;
         2'd1: begin
            if (el1_trap)      begin kind = RSP_TRAP; tgt = 2'd1; end
            else if (el2_gate) begin kind = RSP_TRAP; tgt = 2'd2; end
            else if (el3_gate) begin kind = RSP_TRAP; tgt = 2'd3; end
         end
         2'd2: begin
            if (el2_trap)      begin kind = RSP_TRAP; tgt = 2'd2; end
            else if (el3_gate) begin kind = RSP_TRAP; tgt = 2'd3; end
         end
         default: begin
            if (el3_trap)      begin kind = RSP_TRAP; tgt = 2'd3; end
         end
      endcase
   end
endmodule

// File: rtl/tacmp_canon.sv
module tacmp_canon #(
   parameter int ADDR_W  = 64,
   parameter int VA_BITS = 48
) (
   input  logic [ADDR_W-1:0] din,
   output logic [ADDR_W-1:0] dout
);
   generate
      if (VA_BITS >= ADDR_W) begin : g_full
         assign dout = din;
      end else begin : g_fold
         localparam int UP_W = ADDR_W - VA_BITS;
         logic [UP_W-1:0] upper;
         logic            uniform;
         assign upper   = din[ADDR_W-1:VA_BITS];
         assign uniform = (upper == '0) || (upper == '1);
         assign dout    = uniform ? din
                                  : {{UP_W{din[VA_BITS-1]}}, din[VA_BITS-1:0]};
      end
   endgenerate
endmodule

// File: rtl/tacmp_store.sv
module tacmp_store
   import trace_acmp_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int NPRES  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [IDX_W-1:0]    idx,
   input  logic [ADDR_W-1:0]   wdata,
   output logic [ADDR_W-1:0]   rdata,
   input  logic [ADDR_W-1:0]   cmp_key,
   output logic [MAX_REGS-1:0] cmp_hit
);
   logic [ADDR_W-1:0] vals [MAX_REGS];

   generate
      for (genvar g = 0; g < MAX_REGS; g++) begin : g_reg
         if (g < NPRES) begin : g_live
            logic [ADDR_W-1:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                          val_q <= '0;
               else if (we && (int'(idx) == g))     val_q <= wdata;
            end
            assign vals[g]    = val_q;
            assign cmp_hit[g] = (val_q == cmp_key);
         end else begin : g_void
            assign vals[g]    = '0;
            assign cmp_hit[g] = 1'b0;
         end
      end
   endgenerate

   assign rdata = vals[idx];
endmodule

// File: rtl/trace_acmp_bank.sv
module trace_acmp_bank
   import trace_acmp_pkg::*;
#(
   parameter int NUM_PAIRS = 8,
   parameter int VA_BITS   = 48,
   parameter int NARROW_W  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic                acc_write,
   input  logic [1:0]          acc_op0,
   input  logic [2:0]          acc_op1,
   input  logic [3:0]          acc_crn,
   input  logic [3:0]          acc_crm,
   input  logic [2:0]          acc_op2,
   input  logic [63:0]         acc_wdata,
   input  logic [1:0]          cur_el,
   input  logic                el1_trap,
   input  logic                el2_trap,
   input  logic                el3_trap,
   input  logic                el2_enabled,
   input  logic                el2_is64,
   input  logic                el3_present,
   input  logic                el3_is64,
   input  logic                unit_idle,
   output logic                rsp_valid,
   output logic [1:0]          rsp_kind,
   output logic [1:0]          rsp_tgt_el,
   output logic [5:0]          rsp_class,
   output logic [63:0]         rsp_rdata,
   output logic                wr_busy_err,
   input  logic [63:0]         cmp_addr,
   input  logic                cmp_narrow,
   output logic [15:0]         cmp_hit
);
   localparam int ADDR_W = 64;
   localparam int NPRES  = 2 * NUM_PAIRS;

   generate
      if (NUM_PAIRS < 1 || NPRES > MAX_REGS) begin : g_bad_pairs
         $error("NUM_PAIRS must lie in 1..8");
      end
      if (VA_BITS <= NARROW_W || VA_BITS > ADDR_W) begin : g_bad_va
         $error("VA_BITS must exceed NARROW_W and not exceed 64");
      end
      if (NARROW_W < 1 || NARROW_W >= ADDR_W) begin : g_bad_narrow
         $error("NARROW_W must lie in 1..63");
      end
   endgenerate

   logic             dec_hit, dec_present;
   logic [IDX_W-1:0] dec_idx;
   rsp_kind_e        chain_kind, fin_kind;
   logic [1:0]       chain_tgt;
   logic [ADDR_W-1:0] canon_w, store_rd, cmp_key;
   logic             granted, wr_en, busy_hit;

   tacmp_decode #(.NUM_PAIRS(NUM_PAIRS)) u_dec (
      .op0(acc_op0), .op1(acc_op1), .crn(acc_crn), .crm(acc_crm), .op2(acc_op2),
      .addr_hit(dec_hit), .reg_idx(dec_idx), .present(dec_present)
   );

   tacmp_trap u_trap (
      .el(cur_el), .el1_trap(el1_trap), .el2_trap(el2_trap), .el3_trap(el3_trap),
      .el2_enabled(el2_enabled), .el2_is64(el2_is64),
      .el3_present(el3_present), .el3_is64(el3_is64),
      .kind(chain_kind), .tgt(chain_tgt)
   );

   tacmp_canon #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_canon (
      .din(acc_wdata), .dout(canon_w)
   );

   always_comb begin
      if (!dec_hit)               fin_kind = RSP_NOHIT;
      else if (cur_el == 2'd0)    fin_kind = RSP_UNDEF;
      else if (!dec_present)      fin_kind = RSP_UNDEF;
      else                        fin_kind = chain_kind;
   end

   assign granted  = acc_valid && (fin_kind == RSP_DONE);
   assign wr_en    = granted && acc_write && unit_idle;
   assign busy_hit = granted && acc_write && !unit_idle;
   assign cmp_key  = cmp_narrow ? {{(ADDR_W-NARROW_W){1'b0}}, cmp_addr[NARROW_W-1:0]}
                                : cmp_addr;

   tacmp_store #(.ADDR_W(ADDR_W), .NPRES(NPRES)) u_store (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .idx(dec_idx), .wdata(canon_w),
      .rdata(store_rd), .cmp_key(cmp_key), .cmp_hit(cmp_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_kind    <= RSP_DONE;
         rsp_tgt_el  <= 2'd0;
         rsp_class   <= 6'd0;
         rsp_rdata   <= '0;
         wr_busy_err <= 1'b0;
      end else begin
         rsp_valid   <= acc_valid;
         wr_busy_err <= wr_busy_err | busy_hit;
         if (acc_valid) begin
            rsp_kind   <= fin_kind;
            rsp_tgt_el <= (fin_kind == RSP_TRAP) ? chain_tgt : 2'd0;
            rsp_class  <= (fin_kind == RSP_TRAP) ? TRAP_CLASS : 6'd0;
            rsp_rdata  <= (granted && !acc_write) ? store_rd : '0;
         end
      end
   end
endmodule

// File: rtl/trace_acmp_chk.sv
module trace_acmp_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_valid,
   input logic        acc_write,
   input logic [1:0]  acc_op0,
   input logic [2:0]  acc_op1,
   input logic [3:0]  acc_crn,
   input logic [3:0]  acc_crm,
   input logic [2:0]  acc_op2,
   input logic [1:0]  cur_el,
   input logic        unit_idle,
   input logic        rsp_valid,
   input logic [1:0]  rsp_kind,
   input logic [1:0]  rsp_tgt_el,
   input logic [5:0]  rsp_class,
   input logic [63:0] rsp_rdata,
   input logic        wr_busy_err
);
   // R7
   trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == 2'd2) |-> (rsp_class == 6'h18));

   // R7
   reject_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind != 2'd0) |-> (rsp_rdata == 64'd0));

   // R3
   el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && cur_el == 2'd0 && acc_op0 == 2'b10 && acc_op1 == 3'b001
       && acc_crn == 4'b0010 && !acc_crm[0] && acc_op2[2:1] == 2'b00)
      |=> (rsp_valid && rsp_kind == 2'd1));

   // R11
   busy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_busy_err |=> wr_busy_err);

   // R11
   busy_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !unit_idle) |=> (rsp_kind != 2'd0 || wr_busy_err));

   // R6
   el3_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && cur_el == 2'd3) |=> (rsp_kind != 2'd2 || rsp_tgt_el == 2'd3));
endmodule

bind trace_acmp_bank trace_acmp_chk u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm),
   .acc_op2(acc_op2), .cur_el(cur_el), .unit_idle(unit_idle),
   .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_tgt_el(rsp_tgt_el),
   .rsp_class(rsp_class), .rsp_rdata(rsp_rdata), .wr_busy_err(wr_busy_err)
);

// File: tb/trace_acmp_bank_bench.sv
`timescale 1ns/1ps
module trace_acmp_bank_bench;
   localparam int NP  = 3;
   localparam int NPR = 2 * NP;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        acc_valid = 0, acc_write = 0;
   logic [1:0]  acc_op0 = 0;
   logic [2:0]  acc_op1 = 0;
   logic [3:0]  acc_crn = 0, acc_crm = 0;
   logic [2:0]  acc_op2 = 0;
   logic [63:0] acc_wdata = 0;
   logic [1:0]  cur_el = 0;
   logic        t1 = 0, t2 = 0, t3 = 0, e2en = 0, e2a = 0, e3p = 0, e3a = 0;
   logic        idle = 1;
   logic        rsp_valid, wr_busy_err;
   logic [1:0]  rsp_kind, rsp_tgt_el;
   logic [5:0]  rsp_class;
   logic [63:0] rsp_rdata;
   logic [63:0] cmp_addr = 0;
   logic        cmp_narrow = 0;
   logic [15:0] cmp_hit;

   always #2 clk = ~clk;

   trace_acmp_bank #(.NUM_PAIRS(NP), .VA_BITS(48), .NARROW_W(32)) u_trace_acmp_bank (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm),
      .acc_op2(acc_op2), .acc_wdata(acc_wdata), .cur_el(cur_el),
      .el1_trap(t1), .el2_trap(t2), .el3_trap(t3), .el2_enabled(e2en),
      .el2_is64(e2a), .el3_present(e3p), .el3_is64(e3a), .unit_idle(idle),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_tgt_el(rsp_tgt_el),
      .rsp_class(rsp_class), .rsp_rdata(rsp_rdata), .wr_busy_err(wr_busy_err),
      .cmp_addr(cmp_addr), .cmp_narrow(cmp_narrow), .cmp_hit(cmp_hit)
   );

   typedef struct {
      logic [1:0]  kind;
      logic [1:0]  tgt;
      logic [5:0]  cls;
      logic [63:0] rd;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [63:0] mem [16];
   logic        exp_err = 0;
   int          checks = 0, errors = 0;
   bit          done = 0;

   function automatic logic [63:0] canon(input logic [63:0] w);
      if (w[63:48] == 16'h0000 || w[63:48] == 16'hFFFF) return w;
      return {{16{w[47]}}, w[47:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pop and compare each response
   always @(negedge clk) begin
      if (rst_n && rsp_valid && !done) begin
         exp_t e;
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R8 unexpected response actual kind=%0d expected none", rsp_kind);
         end else begin
            e = sb.pop_front();
            if (rsp_kind !== e.kind || rsp_tgt_el !== e.tgt || rsp_class !== e.cls || rsp_rdata !== e.rd) begin
               errors++;
               $display("FAIL %s actual kind=%0d tgt=%0d cls=%h rd=%h expected kind=%0d tgt=%0d cls=%h rd=%h",
                        e.tag, rsp_kind, rsp_tgt_el, rsp_class, rsp_rdata, e.kind, e.tgt, e.cls, e.rd);
            end
         end
      end
   end

   task automatic ctl(input bit a1, a2, a3, en2, is2, p3, is3);
      @(negedge clk);
      acc_valid = 0;
      t1 = a1; t2 = a2; t3 = a3; e2en = en2; e2a = is2; e3p = p3; e3a = is3;
   endtask

   task automatic access(input bit wr, input logic [1:0] el, input int idx,
                         input logic [63:0] wd, input bit idl, input string tag,
                         input bit bad = 0);
      exp_t e;
      logic [1:0] k, tg;
      k = 2'd0; tg = 2'd0;
      @(negedge clk);
      if (bad)                k = 2'd3;
      else if (el == 2'd0)    k = 2'd1;
      else if (idx >= NPR)    k = 2'd1;
      else if (el == 2'd1) begin
         if (t1)                     begin k = 2; tg = 1; end
         else if (e2en && e2a && t2) begin k = 2; tg = 2; end
         else if (e3p && e3a && t3)  begin k = 2; tg = 3; end
      end else if (el == 2'd2) begin
         if (t2)                     begin k = 2; tg = 2; end
         else if (e3p && e3a && t3)  begin k = 2; tg = 3; end
      end else begin
         if (t3)                     begin k = 2; tg = 3; end
      end
      e.kind = k; e.tgt = tg; e.cls = (k == 2) ? 6'h18 : 6'h00;
      e.rd   = (k == 0 && !wr) ? mem[idx] : 64'd0;
      e.tag  = tag;
      if (k == 0 && wr) begin
         if (idl) mem[idx] = canon(wd);
         else     exp_err = 1;
      end
      sb.push_back(e);
      acc_valid = 1; acc_write = wr; cur_el = el; acc_wdata = wd; idle = idl;
      acc_op0 = 2'b10; acc_op1 = 3'b001; acc_crn = bad ? 4'b0011 : 4'b0010;
      acc_crm = {idx[2:0], 1'b0}; acc_op2 = {2'b00, idx[3]};
   endtask

   task automatic quiet(input int n);
      @(negedge clk);
      acc_valid = 0; idle = 1;
      repeat (n) @(negedge clk);
   endtask

   task automatic cmp_check(input logic [63:0] a, input bit nar, input string tag);
      logic [63:0] key;
      logic [15:0] exp;
      @(negedge clk);
      acc_valid = 0;
      cmp_addr = a; cmp_narrow = nar;
      key = nar ? {32'd0, a[31:0]} : a;
      for (int n = 0; n < 16; n++) exp[n] = (n < NPR) && (mem[n] == key);
      #1 chk(cmp_hit === exp, tag, {48'd0, cmp_hit}, {48'd0, exp});
   endtask

   initial begin
      for (int n = 0; n < 16; n++) mem[n] = 64'd0;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk(rsp_valid === 1'b0, "R13 rsp_valid", {63'd0, rsp_valid}, 64'd0);
      chk(wr_busy_err === 1'b0, "R13 err", {63'd0, wr_busy_err}, 64'd0);
      #1 chk(cmp_hit === 16'h003F, "R13 regs zero", {48'd0, cmp_hit}, 64'h3F);
      rst_n = 1;
      ctl(0, 0, 0, 0, 0, 0, 0);
      // R8 write/read
      access(1, 1, 2, 64'h0000_1234_5678_9ABC, 1, "R8 write idx2");
      access(0, 1, 2, 0, 1, "R8 read idx2");
      // R9 uniform upper bits
      access(1, 1, 5, 64'hFFFF_8000_0000_0010, 1, "R9 write ones");
      access(0, 1, 5, 0, 1, "R9 read ones");
      // R10 mixed upper bits
      access(1, 2, 1, 64'h1234_0000_0000_0040, 1, "R10 write mixed b47=0");
      access(0, 2, 1, 0, 1, "R10 read mixed b47=0");
      access(1, 3, 3, 64'h00F0_8000_0000_0000, 1, "R10 write mixed b47=1");
      access(0, 3, 3, 0, 1, "R10 read mixed b47=1");
      // R2 absent registers
      access(0, 1, 6, 0, 1, "R2 absent idx6");
      access(1, 3, 15, 64'h55, 1, "R2 absent idx15");
      // R3 EL0
      access(0, 0, 0, 0, 1, "R3 el0 present");
      access(1, 0, 9, 64'h1, 1, "R3 el0 absent");
      // R1 not addressed
      access(0, 1, 2, 0, 1, "R1 bad crn read", 1);
      access(1, 1, 2, 64'hDEAD, 1, "R1 bad crn write", 1);
      access(0, 1, 2, 0, 1, "R1 idx2 unchanged");
      // R4 EL1 chain
      ctl(1, 1, 1, 1, 1, 1, 1);
      access(1, 1, 2, 64'hBAD0, 1, "R4 el1 trap to 1");
      ctl(0, 1, 1, 1, 1, 1, 1);
      access(0, 1, 2, 0, 1, "R4 el1 trap to 2");
      ctl(0, 1, 1, 1, 0, 1, 1);
      access(0, 1, 2, 0, 1, "R4 el1 el2 not 64 trap to 3");
      ctl(0, 1, 1, 1, 0, 1, 0);
      access(0, 1, 2, 0, 1, "R4 el1 completes");
      // R7 trapped write had no effect
      access(0, 1, 2, 0, 1, "R7 idx2 after trapped write");
      // R5 EL2 chain
      ctl(1, 1, 0, 0, 0, 0, 0);
      access(0, 2, 4, 0, 1, "R5 el2 trap to 2");
      ctl(1, 0, 1, 0, 0, 1, 1);
      access(0, 2, 4, 0, 1, "R5 el2 trap to 3");
      ctl(1, 0, 1, 0, 0, 0, 1);
      access(0, 2, 4, 0, 1, "R5 el2 completes");
      // R6 EL3
      ctl(1, 1, 0, 1, 1, 1, 1);
      access(0, 3, 5, 0, 1, "R6 el3 ignores lower traps");
      ctl(0, 0, 1, 0, 0, 1, 1);
      access(1, 3, 5, 64'h77, 1, "R6 el3 trap");
      ctl(0, 0, 0, 0, 0, 0, 0);
      access(0, 3, 5, 0, 1, "R7 idx5 after trapped write");
      // R11 write outside Idle
      quiet(1);
      chk(wr_busy_err === 1'b0, "R11 flag clear before", {63'd0, wr_busy_err}, 64'd0);
      access(1, 1, 2, 64'h0000_0000_0000_0999, 0, "R11 busy write");
      access(0, 1, 2, 0, 1, "R11 idx2 unchanged");
      quiet(2);
      chk(wr_busy_err === exp_err, "R11 flag set", {63'd0, wr_busy_err}, {63'd0, exp_err});
      quiet(3);
      chk(wr_busy_err === 1'b1, "R11 flag sticky", {63'd0, wr_busy_err}, 64'd1);
      // R12 compare
      access(1, 1, 0, 64'h0000_0000_8000_1000, 1, "R12 write idx0");
      quiet(2);
      cmp_check(64'h0000_1234_5678_9ABC, 0, "R12 full hit idx2");
      cmp_check(64'hFFFF_FFFF_8000_1000, 1, "R12 narrow zero-extend hit idx0");
      cmp_check(64'hFFFF_FFFF_8000_1000, 0, "R12 full no hit idx0");
      cmp_check(64'd0, 0, "R12 zero key absent bits low");
      quiet(2);
      chk(sb.size() == 0, "R8 all responses seen", 64'(sb.size()), 64'd0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule